// File: doc/BRIEF.md
# UDP Register-Access Packet Engine

This block terminates a minimal request/reply protocol carried over Ethernet, IPv4 and UDP. It receives frames as a byte stream from a MAC, with no preamble and no CRC. It checks only the header fields it needs. The fixed 18-byte control field of each frame is written straight into a bank of control registers, and the bytes that follow that field are streamed to a front-end data port as they arrive. Once the request has been fully received, the block sends a reply frame back to the sender. The reply carries a snapshot of the status inputs and one returned byte for each payload byte of the request. The returned bytes are pulled directly from the front end while the reply is being sent.

Nothing is buffered on chip. The host drives each exchange by sending one request and waiting for its reply. There is no address resolution and there are no management protocols. The block's own MAC address, IP address and UDP port are fixed parameters. The reply is addressed to the sender of the request.

Top module: `udp_reg_engine`

## Requirements
- R1: After reset, tx_valid, dout_valid and din_take are low and every control register bit reads zero.
- R2: In an accepted frame, the bytes at offsets 42 to 59 are written to ctrl_regs in big-endian order. The byte at offset 42 lands in bits [143:136] and the byte at offset 59 lands in bits [7:0]. Control registers change only in the cycle after a received byte.
- R3: In an accepted frame, every byte from offset 60 onward appears on dout_data with dout_valid high, one clock after it was received, in the order received. No other byte appears there.
- R4: A frame is dropped (no control write, no dout byte, no reply) in any of these cases: offsets 12..13 are not 0x0800, offset 14 is not 0x45, offset 23 is not 17, or offsets 36..37 do not equal the UDP_PORT parameter.
- R5: A frame that ends before offset 59 produces no reply and no dout byte. The control bytes it delivered before ending remain written.
- R6: The reply frame is built as follows. Destination MAC is the request's offsets 6..11. Source MAC is LOCAL_MAC. Type is 0x0800. The IP header reads 0x45, 0x00, then four zero bytes for identification and flags, then TTL 0x40 and protocol 0x11. Source IP is LOCAL_IP. Destination IP is the request's offsets 26..29. Source port is UDP_PORT. Destination port is the request's offsets 34..35. The UDP checksum is zero.
- R7: For N payload bytes in the request, the reply's UDP length (offsets 38..39) is 26+N and its IP total length (offsets 16..17) is 46+N.
- R8: The reply's offsets 24..25 hold the ones-complement of the ones-complement sum of the ten 16-bit words at offsets 14..33, where the checksum word itself counts as zero.
- R9: Reply offsets 42..59 hold stat_regs, most significant byte first, as sampled at the clock edge after the one that accepted the request's last byte.
- R10: Reply offsets 60 to 59+N each carry din_data as it stood in a cycle when din_take was high. din_take is high for exactly N cycles per reply.
- R11: The first reply byte appears on tx two clocks after the edge that accepted the request's last byte. The reply is 60+N contiguous valid bytes, and tx_last marks only the final one.
- R12: A frame whose first byte arrives while a reply is pending or in progress is ignored entirely. It causes no control write, no dout byte and no second reply.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_data | input | 8 | Received frame byte |
| rx_valid | input | 1 | rx_data holds a byte this cycle |
| rx_last | input | 1 | Byte is the final one of the frame |
| dout_data | output | 8 | Request payload byte to front end |
| dout_valid | output | 1 | dout_data valid |
| ctrl_regs | output | 144 | Control register bank, big-endian |
| stat_regs | input | 144 | Status words for the reply |
| din_data | input | 8 | Front-end byte returned in the reply |
| din_take | output | 1 | din_data is consumed this cycle |
| tx_data | output | 8 | Reply frame byte |
| tx_valid | output | 1 | tx_data valid |
| tx_last | output | 1 | Final reply byte |

## Verification
Each payload byte appears on dout one clock after it is received. Control bytes land on the same edge as the byte that carries them. Status is sampled one edge after the request's last byte, and the first reply byte shows two edges after that last byte. The bench keeps a free-running edge counter and records, at each falling edge, the reply bytes with their edge numbers. It checks the reply latency as an exact difference of two. It changes the status inputs right after the capture edge, so a capture that comes a cycle early or late shows up as a wrong status byte. Drop and ignore cases are checked after a wait that is longer than a full reply would take.

// File: rtl/udp_eng_pkg.sv
`timescale 1ns / 1ps
package udp_eng_pkg;

    // Byte offsets inside a frame (no preamble, no CRC)
    localparam logic [15:0] OFS_SRC_MAC  = 16'd6;
    localparam logic [15:0] OFS_ETYPE    = 16'd12;
    localparam logic [15:0] OFS_VIHL     = 16'd14;
    localparam logic [15:0] OFS_PROTO    = 16'd23;
    localparam logic [15:0] OFS_SRC_IP   = 16'd26;
    localparam logic [15:0] OFS_SRC_PORT = 16'd34;
    localparam logic [15:0] OFS_DST_PORT = 16'd36;
    localparam logic [15:0] HDR_LEN      = 16'd42;

    localparam logic [15:0] ETYPE_IPV4  = 16'h0800;
    localparam logic [7:0]  VIHL_V4     = 8'h45;
    localparam logic [7:0]  PROTO_UDP   = 8'd17;
    localparam logic [7:0]  TTL_DEF     = 8'h40;
    localparam logic [15:0] UDP_HDR_LEN = 16'd8;
    localparam logic [15:0] IP_HDR_LEN  = 16'd20;

    typedef struct packed {
        logic [47:0] mac;
        logic [31:0] ip;
        logic [15:0] port;
    } peer_t;

    // Ones-complement checksum of the fixed-layout reply IP header
    function automatic logic [15:0] ip_hdr_csum(input logic [31:0] sip,
                                                input logic [31:0] dip,
                                                input logic [15:0] tot);
        logic [31:0] s;
        s = {16'h0, VIHL_V4, 8'h00} + {16'h0, tot} + {16'h0, TTL_DEF, PROTO_UDP}
          + {16'h0, sip[31:16]} + {16'h0, sip[15:0]}
          + {16'h0, dip[31:16]} + {16'h0, dip[15:0]};
        s = {16'h0, s[31:16]} + {16'h0, s[15:0]};
        s = {16'h0, s[31:16]} + {16'h0, s[15:0]};
        return ~s[15:0];
    endfunction

endpackage

// File: rtl/udp_rx_parse.sv
`timescale 1ns / 1ps
module udp_rx_parse
    import udp_eng_pkg::*;
#(
    parameter int          CTRL_BYTES = 18,
    parameter int          CNT_W      = 16,
    parameter logic [15:0] UDP_PORT   = 16'h1388
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [7:0]              rx_data,
    input  logic                    rx_valid,
    input  logic                    rx_last,
    input  logic                    busy,
    output logic [7:0]              dout_data,
    output logic                    dout_valid,
    output logic [CTRL_BYTES*8-1:0] ctrl,
    output logic                    start,
    output peer_t                   peer,
    output logic [CNT_W-1:0]        pay_len
);
    localparam int          CW      = CTRL_BYTES * 8;
    localparam logic [15:0] PAY_OFS = HDR_LEN + 16'(CTRL_BYTES);

    typedef struct packed {
        logic [15:0]      idx;
        logic             ok;
        peer_t            peer;
        logic [CW-1:0]    ctrl;
        logic [CNT_W-1:0] cnt;
        logic [7:0]       dout;
        logic             dv;
        logic             start;
    } rx_state_t;

    rx_state_t q, d;
    logic      ok_in;
    logic      fail;
    int        i;

    always_comb begin
        d       = q;
        d.dv    = 1'b0;
        d.start = 1'b0;
        ok_in   = 1'b0;
        fail    = 1'b0;
        i       = int'(q.idx);
        if (rx_valid) begin
            ok_in = (q.idx == 16'd0) ? !(busy || q.start) : q.ok;
            if (q.idx == OFS_ETYPE)            fail = (rx_data != ETYPE_IPV4[15:8]);
            if (q.idx == OFS_ETYPE + 16'd1)    fail = (rx_data != ETYPE_IPV4[7:0]);
            if (q.idx == OFS_VIHL)             fail = (rx_data != VIHL_V4);
            if (q.idx == OFS_PROTO)            fail = (rx_data != PROTO_UDP);
            if (q.idx == OFS_DST_PORT)         fail = (rx_data != UDP_PORT[15:8]);
            if (q.idx == OFS_DST_PORT + 16'd1) fail = (rx_data != UDP_PORT[7:0]);
            if (q.idx == 16'd0) d.cnt = '0;
            if (ok_in) begin
                if (q.idx >= OFS_SRC_MAC && q.idx < OFS_SRC_MAC + 16'd6)
                    d.peer.mac[8*(int'(OFS_SRC_MAC)+5-i) +: 8] = rx_data;
                if (q.idx >= OFS_SRC_IP && q.idx < OFS_SRC_IP + 16'd4)
                    d.peer.ip[8*(int'(OFS_SRC_IP)+3-i) +: 8] = rx_data;
                if (q.idx >= OFS_SRC_PORT && q.idx < OFS_SRC_PORT + 16'd2)
                    d.peer.port[8*(int'(OFS_SRC_PORT)+1-i) +: 8] = rx_data;
                if (q.idx >= HDR_LEN && q.idx < PAY_OFS)
                    d.ctrl[8*(int'(PAY_OFS)-1-i) +: 8] = rx_data;
                if (q.idx >= PAY_OFS) begin
                    d.dv   = 1'b1;
                    d.dout = rx_data;
                    d.cnt  = q.cnt + 1'b1;
                end
            end
            d.ok  = ok_in && !fail;
            d.idx = (q.idx == 16'hFFFF) ? q.idx : q.idx + 16'd1;
            if (rx_last) begin
                d.idx   = 16'd0;
                d.ok    = 1'b0;
                d.start = ok_in && !fail && (q.idx >= PAY_OFS - 16'd1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign dout_data  = q.dout;
    assign dout_valid = q.dv;
    assign ctrl       = q.ctrl;
    assign start      = q.start;
    assign peer       = q.peer;
    assign pay_len    = q.cnt;

    // R3
    fwd_follows_rx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.dv |-> $past(rx_valid));

    // R2
    ctrl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rx_valid) |-> $stable(q.ctrl));

    // R11
    start_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.start |-> $past(rx_valid && rx_last));

endmodule

// File: rtl/udp_tx_build.sv
`timescale 1ns / 1ps
module udp_tx_build
    import udp_eng_pkg::*;
#(
    parameter int          CTRL_BYTES = 18,
    parameter int          CNT_W      = 16,
    parameter logic [47:0] LOCAL_MAC  = 48'h02_12_34_56_78_9A,
    parameter logic [31:0] LOCAL_IP   = 32'hC0A8_0164,
    parameter logic [15:0] UDP_PORT   = 16'h1388
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  peer_t                   peer,
    input  logic [CNT_W-1:0]        pay_len,
    input  logic [CTRL_BYTES*8-1:0] stat_regs,
    input  logic [7:0]              din_data,
    output logic                    din_take,
    output logic                    busy,
    output logic [7:0]              tx_data,
    output logic                    tx_valid,
    output logic                    tx_last
);
    localparam int          CW      = CTRL_BYTES * 8;
    localparam int          HW      = int'(HDR_LEN) * 8;
    localparam logic [15:0] PAY_OFS = HDR_LEN + 16'(CTRL_BYTES);

    typedef struct packed {
        logic          send;
        logic [15:0]   pos;
        peer_t         peer;
        logic [15:0]   len;
        logic [CW-1:0] stat;
        logic [7:0]    txd;
        logic          txv;
        logic          txl;
    } tx_state_t;

    tx_state_t   q, d;
    logic [15:0] udp_len, ip_len, csum, last_pos;
    logic [HW-1:0] hdr;
    logic [7:0]  cur;
    int          i;

    always_comb begin
        udp_len  = UDP_HDR_LEN + 16'(CTRL_BYTES) + q.len;
        ip_len   = udp_len + IP_HDR_LEN;
        csum     = ip_hdr_csum(LOCAL_IP, q.peer.ip, ip_len);
        last_pos = PAY_OFS + q.len - 16'd1;
        hdr = {q.peer.mac, LOCAL_MAC, ETYPE_IPV4, VIHL_V4, 8'h00, ip_len,
               16'h0000, 16'h0000, TTL_DEF, PROTO_UDP, csum,
               LOCAL_IP, q.peer.ip, UDP_PORT, q.peer.port, udp_len, 16'h0000};
        i = int'(q.pos);
        if (q.pos < HDR_LEN)      cur = hdr[8*(int'(HDR_LEN)-1-i) +: 8];
        else if (q.pos < PAY_OFS) cur = q.stat[8*(int'(PAY_OFS)-1-i) +: 8];
        else                      cur = din_data;

        d     = q;
        d.txv = 1'b0;
        d.txl = 1'b0;
        if (!q.send) begin
            if (start) begin
                d.send = 1'b1;
                d.pos  = 16'd0;
                d.peer = peer;
                d.len  = 16'(pay_len);
                d.stat = stat_regs;
            end
        end else begin
            d.txv = 1'b1;
            d.txd = cur;
            d.txl = (q.pos == last_pos);
            d.pos = q.pos + 16'd1;
            if (q.pos == last_pos) d.send = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign din_take = q.send && (q.pos >= PAY_OFS);
    assign busy     = q.send;
    assign tx_data  = q.txd;
    assign tx_valid = q.txv;
    assign tx_last  = q.txl;

    // R11
    tx_contig_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.txv && !q.txl) |=> q.txv);

    // R11
    tx_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.txl |=> !q.txv);

    // R10
    din_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        din_take |=> q.txv);

    // R12
    start_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !q.send);

endmodule

// File: rtl/udp_reg_engine.sv
`timescale 1ns / 1ps
module udp_reg_engine
    import udp_eng_pkg::*;
#(
    parameter int          CTRL_BYTES = 18,
    parameter int          CNT_W      = 16,
    parameter logic [47:0] LOCAL_MAC  = 48'h02_12_34_56_78_9A,
    parameter logic [31:0] LOCAL_IP   = 32'hC0A8_0164,
    parameter logic [15:0] UDP_PORT   = 16'h1388
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [7:0]              rx_data,
    input  logic                    rx_valid,
    input  logic                    rx_last,
    output logic [7:0]              dout_data,
    output logic                    dout_valid,
    output logic [CTRL_BYTES*8-1:0] ctrl_regs,
    input  logic [CTRL_BYTES*8-1:0] stat_regs,
    input  logic [7:0]              din_data,
    output logic                    din_take,
    output logic [7:0]              tx_data,
    output logic                    tx_valid,
    output logic                    tx_last
);
    logic             start;
    logic             busy;
    peer_t            peer;
    logic [CNT_W-1:0] pay_len;

    udp_rx_parse #(
        .CTRL_BYTES(CTRL_BYTES), .CNT_W(CNT_W), .UDP_PORT(UDP_PORT)
    ) u_rx (
        .clk(clk), .rst_n(rst_n),
        .rx_data(rx_data), .rx_valid(rx_valid), .rx_last(rx_last),
        .busy(busy),
        .dout_data(dout_data), .dout_valid(dout_valid),
        .ctrl(ctrl_regs), .start(start), .peer(peer), .pay_len(pay_len)
    );

    udp_tx_build #(
        .CTRL_BYTES(CTRL_BYTES), .CNT_W(CNT_W), .LOCAL_MAC(LOCAL_MAC),
        .LOCAL_IP(LOCAL_IP), .UDP_PORT(UDP_PORT)
    ) u_tx (
        .clk(clk), .rst_n(rst_n),
        .start(start), .peer(peer), .pay_len(pay_len), .stat_regs(stat_regs),
        .din_data(din_data), .din_take(din_take), .busy(busy),
        .tx_data(tx_data), .tx_valid(tx_valid), .tx_last(tx_last)
    );

endmodule

// File: tb/udp_reg_engine_test.sv
`timescale 1ns / 1ps
module udp_reg_engine_test;
    localparam int          CB        = 18;
    localparam logic [47:0] LOCAL_MAC = 48'h02_12_34_56_78_9A;
    localparam logic [31:0] LOCAL_IP  = 32'hC0A8_0164;
    localparam logic [15:0] PORT      = 16'h1388;

    // {ethertype, ver/ihl, protocol, dst port, payload count, accepted}
    localparam logic [56:0] VEC [8] = '{
        {16'h0800, 8'h45, 8'h11, 16'h1388, 8'd4,  1'b1},
        {16'h0800, 8'h45, 8'h11, 16'h1388, 8'd0,  1'b1},
        {16'h0800, 8'h45, 8'h11, 16'h1388, 8'd13, 1'b1},
        {16'h86DD, 8'h45, 8'h11, 16'h1388, 8'd3,  1'b0},
        {16'h0800, 8'h45, 8'h06, 16'h1388, 8'd3,  1'b0},
        {16'h0800, 8'h45, 8'h11, 16'h1389, 8'd3,  1'b0},
        {16'h0800, 8'h46, 8'h11, 16'h1388, 8'd3,  1'b0},
        {16'h0800, 8'h45, 8'h11, 16'h1388, 8'd1,  1'b1}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [7:0]    rx_data = '0;
    logic          rx_valid = 1'b0;
    logic          rx_last = 1'b0;
    logic [7:0]    dout_data;
    logic          dout_valid;
    logic [CB*8-1:0] ctrl_regs;
    logic [CB*8-1:0] stat = '0;
    logic [7:0]    din_data;
    logic          din_take;
    logic [7:0]    tx_data;
    logic          tx_valid;
    logic          tx_last;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int din_cnt = 0;
    int tx_n = 0;
    int do_n = 0;
    logic [7:0] fr   [0:255];
    int         fr_len;
    logic [7:0] txb  [0:4095];
    logic       txl  [0:4095];
    int         txc  [0:4095];
    logic [7:0] dob  [0:4095];
    logic [7:0] e    [0:59];
    logic [7:0] exp_ctrl [0:CB-1];

    udp_reg_engine #(.CTRL_BYTES(CB), .LOCAL_MAC(LOCAL_MAC), .LOCAL_IP(LOCAL_IP),
                     .UDP_PORT(PORT)) uut (
        .clk(clk), .rst_n(rst_n), .rx_data(rx_data), .rx_valid(rx_valid),
        .rx_last(rx_last), .dout_data(dout_data), .dout_valid(dout_valid),
        .ctrl_regs(ctrl_regs), .stat_regs(stat), .din_data(din_data),
        .din_take(din_take), .tx_data(tx_data), .tx_valid(tx_valid), .tx_last(tx_last)
    );

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;
    always @(posedge clk) if (din_take) din_cnt <= din_cnt + 1;
    assign din_data = 8'hA0 + din_cnt[7:0];

    always @(negedge clk) begin
        if (tx_valid) begin
            txb[tx_n] = tx_data; txl[tx_n] = tx_last; txc[tx_n] = cyc;
            tx_n = tx_n + 1;
        end
        if (dout_valid) begin
            dob[do_n] = dout_data;
            do_n = do_n + 1;
        end
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] expv);
        checks++;
        if (act !== expv) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, expv);
        end
    endtask

    task automatic set_stat(input int seed);
        for (int k = 0; k < CB; k++) stat[(CB-1-k)*8 +: 8] = 8'(seed + 3*k + 8'h11);
    endtask

    task automatic build(input int seed, input logic [15:0] et, input logic [7:0] vi,
                         input logic [7:0] pr, input logic [15:0] dp, input int n);
        logic [47:0] smac;
        logic [31:0] sip;
        logic [15:0] tl, ul;
        smac = {40'h0A1B2C3D4E, 8'(seed)};
        sip  = {24'hC0A80A, 8'(seed)};
        tl = 16'(46 + n); ul = 16'(26 + n);
        for (int k = 0; k < 6; k++) begin
            fr[k]   = LOCAL_MAC[8*(5-k) +: 8];
            fr[6+k] = smac[8*(5-k) +: 8];
        end
        fr[12] = et[15:8]; fr[13] = et[7:0]; fr[14] = vi; fr[15] = 8'h00;
        fr[16] = tl[15:8]; fr[17] = tl[7:0];
        for (int k = 18; k < 22; k++) fr[k] = 8'h00;
        fr[22] = 8'h40; fr[23] = pr; fr[24] = 8'h00; fr[25] = 8'h00;
        for (int k = 0; k < 4; k++) begin
            fr[26+k] = sip[8*(3-k) +: 8];
            fr[30+k] = LOCAL_IP[8*(3-k) +: 8];
        end
        fr[34] = 8'hC0; fr[35] = 8'(seed); fr[36] = dp[15:8]; fr[37] = dp[7:0];
        fr[38] = ul[15:8]; fr[39] = ul[7:0]; fr[40] = 8'h00; fr[41] = 8'h00;
        for (int k = 0; k < CB; k++) fr[42+k] = 8'(seed*16 + k) ^ 8'h5A;
        for (int j = 0; j < n; j++) fr[60+j] = 8'(seed*7 + j + 1);
        fr_len = 60 + n;
    endtask

    task automatic send();
        for (int k = 0; k < fr_len; k++) begin
            @(negedge clk);
            rx_valid = 1'b1; rx_data = fr[k]; rx_last = (k == fr_len - 1);
        end
        @(negedge clk);
        rx_valid = 1'b0; rx_last = 1'b0;
    endtask

    task automatic check_ctrl(input string req);
        for (int k = 0; k < CB; k++)
            chk(req, 64'(ctrl_regs[(CB-1-k)*8 +: 8]), 64'(exp_ctrl[k]));
    endtask

    task automatic run_accept(input int seed, input int n);
        int tb, db, dn, la;
        logic [31:0] s;
        logic [15:0] tl, ul;
        tb = tx_n; db = do_n; dn = din_cnt;
        set_stat(seed);
        build(seed, 16'h0800, 8'h45, 8'h11, PORT, n);
        send();
        la = cyc;
        @(negedge clk);
        stat = ~stat;
        repeat (90 + n) @(negedge clk);
        // R2 control bytes
        for (int k = 0; k < CB; k++) exp_ctrl[k] = 8'(seed*16 + k) ^ 8'h5A;
        check_ctrl("R2");
        // R3 forwarded payload
        chk("R3", 64'(do_n - db), 64'(n));
        for (int j = 0; j < n; j++) chk("R3", 64'(dob[db+j]), 64'(8'(seed*7 + j + 1)));
        // R11 length, latency, last marker
        chk("R11", 64'(tx_n - tb), 64'(60 + n));
        chk("R11", 64'(txc[tb] - la), 64'd2);
        for (int k = 0; k < 60 + n; k++) chk("R11", 64'(txl[tb+k]), 64'(k == 59 + n));
        // expected header
        tl = 16'(46 + n); ul = 16'(26 + n);
        for (int k = 0; k < 6; k++) begin
            e[k] = (k == 5) ? 8'(seed) : 8'(48'h0A1B2C3D4E00 >> (8*(5-k)));
            e[6+k] = LOCAL_MAC[8*(5-k) +: 8];
        end
        e[12] = 8'h08; e[13] = 8'h00; e[14] = 8'h45; e[15] = 8'h00;
        e[16] = tl[15:8]; e[17] = tl[7:0];
        for (int k = 18; k < 22; k++) e[k] = 8'h00;
        e[22] = 8'h40; e[23] = 8'h11; e[24] = 8'h00; e[25] = 8'h00;
        for (int k = 0; k < 4; k++) begin
            e[26+k] = LOCAL_IP[8*(3-k) +: 8];
            e[30+k] = (k == 3) ? 8'(seed) : 8'(32'hC0A80A00 >> (8*(3-k)));
        end
        e[34] = PORT[15:8]; e[35] = PORT[7:0]; e[36] = 8'hC0; e[37] = 8'(seed);
        e[38] = ul[15:8]; e[39] = ul[7:0]; e[40] = 8'h00; e[41] = 8'h00;
        s = 32'h0;
        for (int w = 0; w < 10; w++) s = s + {16'h0, e[14+2*w], e[15+2*w]};
        s = {16'h0, s[31:16]} + {16'h0, s[15:0]};
        s = {16'h0, s[31:16]} + {16'h0, s[15:0]};
        e[24] = ~s[15:8]; e[25] = ~s[7:0];
        for (int k = 0; k < 42; k++)
            chk((k == 16 || k == 17 || k == 38 || k == 39) ? "R7" :
                (k == 24 || k == 25) ? "R8" : "R6", 64'(txb[tb+k]), 64'(e[k]));
        // R9 status snapshot
        for (int k = 0; k < CB; k++) chk("R9", 64'(txb[tb+42+k]), 64'(8'(seed + 3*k + 8'h11)));
        // R10 returned data
        chk("R10", 64'(din_cnt - dn), 64'(n));
        for (int j = 0; j < n; j++) chk("R10", 64'(txb[tb+60+j]), 64'(8'(8'hA0 + dn + j)));
    endtask

    task automatic run_drop(input int seed, input logic [15:0] et, input logic [7:0] vi,
                            input logic [7:0] pr, input logic [15:0] dp, input int n);
        int tb, db;
        tb = tx_n; db = do_n;
        build(seed, et, vi, pr, dp, n);
        send();
        repeat (100) @(negedge clk);
        chk("R4", 64'(tx_n - tb), 64'd0);
        chk("R4", 64'(do_n - db), 64'd0);
        check_ctrl("R4");
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        fails++;
        $display("FAIL R11 watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int tb, db;
        for (int k = 0; k < CB; k++) exp_ctrl[k] = 8'h00;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1", 64'(tx_valid), 64'd0);
        chk("R1", 64'(dout_valid), 64'd0);
        chk("R1", 64'(din_take), 64'd0);
        check_ctrl("R1");

        // vector table
        for (int v = 0; v < 8; v++) begin
            logic [56:0] vr;
            vr = VEC[v];
            if (vr[0]) run_accept(v + 1, int'(vr[8:1]));
            else       run_drop(v + 1, vr[56:41], vr[40:33], vr[32:25], vr[24:9], int'(vr[8:1]));
        end

        // R5 short frame: 50 bytes, control bytes 0..7 land, no reply
        tb = tx_n; db = do_n;
        build(20, 16'h0800, 8'h45, 8'h11, PORT, 0);
        fr_len = 50;
        send();
        repeat (100) @(negedge clk);
        for (int k = 0; k < 8; k++) exp_ctrl[k] = 8'(20*16 + k) ^ 8'h5A;
        chk("R5", 64'(tx_n - tb), 64'd0);
        chk("R5", 64'(do_n - db), 64'd0);
        check_ctrl("R5");

        // R12 frame arriving during a reply
        tb = tx_n; db = do_n;
        build(10, 16'h0800, 8'h45, 8'h11, PORT, 4);
        send();
        @(negedge clk);
        build(11, 16'h0800, 8'h45, 8'h11, PORT, 2);
        send();
        repeat (120) @(negedge clk);
        for (int k = 0; k < CB; k++) exp_ctrl[k] = 8'(10*16 + k) ^ 8'h5A;
        chk("R12", 64'(tx_n - tb), 64'd64);
        chk("R12", 64'(do_n - db), 64'd4);
        chk("R12", 64'(txb[tb+5]), 64'd10);
        check_ctrl("R12");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule